// File: doc/BRIEF.md
# Serial CRC-8 Identification Checker

This block consumes a serial bit stream one bit per strobe and runs an 8-bit cyclic redundancy check over it using the generator x^8 + x^5 + x^4 + 1. Bits arrive least significant bit first. The register is advanced in reflected form with feedback mask 0x8C and starts from 0x00.

In identification mode, the block receives a 64-bit identification code. The lower 56 bits form the payload and feed the CRC. The top eight bits carry the stored check byte and go into a separate compare register. Once the last bit has arrived, a one-cycle done pulse reports whether the stored byte equals the computed CRC.

In streaming mode, the block accumulates over any number of bytes. It is used to check command, address or data bytes that are followed by their own CRC byte. After each byte boundary it reports whether the residue is zero, which is what a correct trailing CRC byte leaves behind. Assembling bytes from the bus is left to the surrounding logic.

Top module: `crc8_id_checker`

## Requirements
- R1: Each accepted bit updates the CRC as follows. The feedback equals CRC bit 0 XOR the input bit. The register shifts right by one. When the feedback is 1, the mask 0x8C is XORed in. For example, the byte 0x01 fed LSB first from 0x00 gives 0x5E.
- R2: A clear sets the CRC to 0x00 and sets done and match to 0. When clear and bitValid are high in the same cycle, clear wins and the bit is dropped.
- R3: After reset, crcOut is 0x00 and done and match are 0.
- R4: In identification mode (modeStream = 0), the first 56 accepted bits after a clear feed the CRC. After bit 55, crcOut equals the CRC of those bits.
- R5: In identification mode, bits 56 to 63 go into the compare register, with bit 56 as its LSB. crcOut does not change while they arrive.
- R6: In the cycle after bit 63 is accepted, done is 1 for exactly one cycle. match is 1 exactly when the stored top byte equals the CRC of the payload.
- R7: In identification mode, bits accepted after the 64th and before the next clear change neither crcOut nor done nor match.
- R8: In streaming mode (modeStream = 1), every accepted bit feeds the CRC. After every 8th accepted bit since the clear, done pulses for one cycle and match is 1 exactly when the new CRC is 0x00.
- R9: A cycle with bitValid and clear both low leaves crcOut unchanged and done low.
- R10: match keeps its value until the next clear or the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Restart the computation; takes priority over bitValid |
| bitValid | input | 1 | bitData holds a new bit this cycle |
| bitData | input | 1 | Serial data bit, least significant first |
| modeStream | input | 1 | 0 selects identification check, 1 selects streaming; hold it steady between clears |
| crcOut | output | 8 | Current CRC register |
| done | output | 1 | One-cycle pulse at the end of an identification code or of each byte |
| match | output | 1 | Check result, valid from the done pulse onwards |

## Verification
The bench builds the block with its default parameters: an 8-bit CRC, mask 0x8C and a 64-bit code. At this size every one of the 64 single-bit corruptions of a code can be tried, alongside dozens of correct codes. Streaming runs of one to six bytes cover every byte count up to the point where byte-boundary pulses repeat several times, each run both with its correct trailing CRC byte and with a corrupted one. Expected CRCs come from a bit loop in the bench that follows the update rule in the requirements.

// File: rtl/crc8_id_pkg.sv
package crc8_id_pkg;

  // Strobes passed from the control to the datapath, one cycle each.
  typedef struct packed {
    logic clrAll;    // restart the datapath
    logic shiftCrc;  // advance the CRC with the current bit
    logic shiftCmp;  // shift the current bit into the compare register
    logic endId;     // last bit of an identification code
    logic endByte;   // last bit of a byte in streaming mode
  } ctrlStrobe_t;

endpackage

// File: rtl/crc8_id_ctrl.sv
module crc8_id_ctrl
  import crc8_id_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CRC_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        bitValid,
  input  logic        modeStream,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W  = $clog2(ID_W) + 1;
  localparam int BYTE_W = $clog2(CRC_W);
  localparam int PAY_N  = ID_W - CRC_W;

  logic [CNT_W-1:0] bitCnt;
  logic             idFull;
  logic             accept;

  assign idFull = (bitCnt == CNT_W'(ID_W));
  assign accept = bitValid && !clear;

  always_comb begin
    strobe        = '0;
    strobe.clrAll = clear;
    if (accept) begin
      if (modeStream) begin
        strobe.shiftCrc = 1'b1;
        strobe.endByte  = (bitCnt[BYTE_W-1:0] == {BYTE_W{1'b1}});
      end else if (!idFull) begin
        if (bitCnt < CNT_W'(PAY_N)) strobe.shiftCrc = 1'b1;
        else                        strobe.shiftCmp = 1'b1;
        strobe.endId = (bitCnt == CNT_W'(ID_W - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (clear) begin
      bitCnt <= '0;
    end else if (bitValid) begin
      if (modeStream || !idFull) bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/crc8_id_datapath.sv
module crc8_id_datapath
  import crc8_id_pkg::*;
#(
  parameter int               CRC_W     = 8,
  parameter logic [CRC_W-1:0] POLY_MASK = 8'h8C,
  parameter logic [CRC_W-1:0] CRC_INIT  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             bitData,
  output logic [CRC_W-1:0] crcOut,
  output logic             done,
  output logic             match
);

  logic [CRC_W-1:0] crcReg, crcNext;
  logic [CRC_W-1:0] cmpReg, cmpNext;
  logic             feedback;

  // Reflected single-bit step; the mask is applied bit by bit.
  assign feedback = crcReg[0] ^ bitData;
  for (genvar g = 0; g < CRC_W; g++) begin : gStep
    if (g == CRC_W - 1) begin : gTop
      assign crcNext[g] = feedback & POLY_MASK[g];
    end else begin : gMid
      assign crcNext[g] = crcReg[g+1] ^ (feedback & POLY_MASK[g]);
    end
  end

  assign cmpNext = {bitData, cmpReg[CRC_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= CRC_INIT;
      cmpReg <= '0;
      done   <= 1'b0;
      match  <= 1'b0;
    end else if (strobe.clrAll) begin
      crcReg <= CRC_INIT;
      cmpReg <= '0;
      done   <= 1'b0;
      match  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.shiftCrc) crcReg <= crcNext;
      if (strobe.shiftCmp) cmpReg <= cmpNext;
      if (strobe.endId) begin
        done  <= 1'b1;
        match <= (cmpNext == crcReg);
      end
      if (strobe.endByte) begin
        done  <= 1'b1;
        match <= (crcNext == '0);
      end
    end
  end

  assign crcOut = crcReg;

endmodule

// File: rtl/crc8_id_checker.sv
module crc8_id_checker
  import crc8_id_pkg::*;
#(
  parameter int          ID_W      = 64,
  parameter int          CRC_W     = 8,
  parameter logic [7:0]  POLY_MASK = 8'h8C,
  parameter logic [7:0]  CRC_INIT  = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       bitValid,
  input  logic       bitData,
  input  logic       modeStream,
  output logic [7:0] crcOut,
  output logic       done,
  output logic       match
);

  ctrlStrobe_t strobe;

  crc8_id_ctrl #(
    .ID_W (ID_W),
    .CRC_W(CRC_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .bitValid  (bitValid),
    .modeStream(modeStream),
    .strobe    (strobe)
  );

  crc8_id_datapath #(
    .CRC_W    (CRC_W),
    .POLY_MASK(POLY_MASK),
    .CRC_INIT (CRC_INIT)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bitData(bitData),
    .crcOut (crcOut),
    .done   (done),
    .match  (match)
  );

endmodule

// File: rtl/crc8_id_checker_sva.sv
module crc8_id_checker_sva #(
  parameter int         ID_W     = 64,
  parameter int         CRC_W    = 8,
  parameter logic [7:0] CRC_INIT = 8'h00
) (
  input logic       clk,
  input logic       rstN,
  input logic       clear,
  input logic       bitValid,
  input logic       modeStream,
  input logic [7:0] crcOut,
  input logic       done,
  input logic       match
);

  localparam int CNT_W = $clog2(ID_W) + 1;
  localparam int PAY_N = ID_W - CRC_W;

  // Independent count of accepted bits since the last clear, saturating.
  logic [CNT_W-1:0] chkCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     chkCnt <= '0;
    else if (clear)                                chkCnt <= '0;
    else if (bitValid && chkCnt != CNT_W'(ID_W))   chkCnt <= chkCnt + 1'b1;
  end

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (crcOut == CRC_INIT) && !done && !match);

  p_crc_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStream && !clear && bitValid && chkCnt >= CNT_W'(PAY_N)) |=> $stable(crcOut));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_extra_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStream && !clear && bitValid && chkCnt == CNT_W'(ID_W))
      |=> !done && $stable(crcOut) && $stable(match));

  p_zero_residue_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeStream && done) |-> (match == (crcOut == 8'h00)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !bitValid) |=> $stable(crcOut) && !done);

  p_match_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !bitValid) |=> $stable(match));

endmodule

bind crc8_id_checker crc8_id_checker_sva #(
  .ID_W    (ID_W),
  .CRC_W   (CRC_W),
  .CRC_INIT(CRC_INIT)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .clear     (clear),
  .bitValid  (bitValid),
  .modeStream(modeStream),
  .crcOut    (crcOut),
  .done      (done),
  .match     (match)
);

// File: tb/crc8_id_checker_test.sv
module crc8_id_checker_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clear = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitData = 1'b0;
  logic       modeStream = 1'b0;
  logic [7:0] crcOut;
  logic       done;
  logic       match;

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] lcgState = 64'h1234_5678_9ABC_DEF1;

  always #2 clk = ~clk;

  crc8_id_checker uut (
    .clk(clk), .rstN(rstN), .clear(clear), .bitValid(bitValid),
    .bitData(bitData), .modeStream(modeStream),
    .crcOut(crcOut), .done(done), .match(match)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  function automatic logic [7:0] refBit(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    c  = c >> 1;
    if (fb) c = c ^ 8'h8C;
    return c;
  endfunction

  function automatic logic [7:0] refByte(input logic [7:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) c = refBit(c, d[i]);
    return c;
  endfunction

  function automatic logic [7:0] refPayload(input logic [63:0] id);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) c = refBit(c, id[i]);
    return c;
  endfunction

  function automatic logic [63:0] nextRand();
    lcgState = lcgState * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcgState;
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitValid = 1'b1;
    bitData  = b;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
  endtask

  task automatic clearPulse();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  // Runs one identification code; expMatch computed from the requirements.
  task automatic runId(input logic [63:0] id, input bit fullChecks);
    logic [7:0] payCrc;
    payCrc = refPayload(id);
    modeStream = 1'b0;
    clearPulse();
    for (int i = 0; i < 64; i++) begin
      sendBit(id[i]);
      if (fullChecks && i == 55) check("R4 crc after payload", crcOut, payCrc);
      if (fullChecks && i == 62) check("R5 crc frozen during stored byte", crcOut, payCrc);
    end
    check("R6 done after bit 63", done, 1'b1);
    check("R6 match value", match, (id[63:56] == payCrc));
    if (fullChecks) begin
      @(negedge clk);
      check("R6 done lasts one cycle", done, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [63:0] id;
    logic [7:0]  pay;
    logic [7:0]  held;
    logic [7:0]  bytes [6];
    logic [7:0]  c;
    logic        m;

    repeat (3) @(negedge clk);
    check("R3 reset crc", crcOut, 8'h00);
    check("R3 reset done", done, 1'b0);
    check("R3 reset match", match, 1'b0);
    rstN = 1'b1;

    // R1: fixed vector, byte 0x01 gives 0x5E
    modeStream = 1'b1;
    clearPulse();
    sendByte(8'h01);
    check("R1 crc of 0x01", crcOut, 8'h5E);
    check("R8 done at byte end", done, 1'b1);
    check("R8 nonzero residue", match, 1'b0);

    // R2: clear beats a simultaneous bit
    sendBit(1'b1);
    @(negedge clk);
    clear = 1'b1; bitValid = 1'b1; bitData = 1'b1;
    @(negedge clk);
    clear = 1'b0; bitValid = 1'b0;
    check("R2 clear priority crc", crcOut, 8'h00);
    check("R2 clear done", done, 1'b0);
    check("R2 clear match", match, 1'b0);

    // R4/R5/R6: sweep of correct identification codes
    for (int k = 0; k < 40; k++) begin
      id = nextRand();
      id[63:56] = refPayload(id);
      runId(id, 1'b1);
    end

    // R6: every single-bit corruption of two codes
    for (int k = 0; k < 2; k++) begin
      id = nextRand();
      id[63:56] = refPayload(id);
      for (int b = 0; b < 64; b++) runId(id ^ (64'd1 << b), 1'b0);
    end

    // R7/R9/R10: bits past the code, idle cycles
    id = nextRand();
    id[63:56] = refPayload(id);
    runId(id, 1'b0);
    held = crcOut;
    m    = match;
    repeat (5) @(negedge clk);
    check("R9 idle crc stable", crcOut, held);
    check("R10 match held", match, m);
    for (int i = 0; i < 8; i++) begin
      sendBit(i[0]);
      check("R7 extra bit done", done, 1'b0);
    end
    check("R7 extra bits crc", crcOut, held);
    check("R7 extra bits match", match, m);

    // R8: streaming runs with correct and corrupted trailing byte
    for (int n = 1; n <= 6; n++) begin
      for (int t = 0; t < 6; t++) begin
        for (int corrupt = 0; corrupt < 2; corrupt++) begin
          modeStream = 1'b1;
          clearPulse();
          c = 8'h00;
          for (int j = 0; j < n; j++) begin
            if (corrupt == 0) bytes[j] = nextRand() >> 24;
            sendByte(bytes[j]);
            c = refByte(c, bytes[j]);
            check("R8 running crc", crcOut, c);
            check("R8 byte done", done, 1'b1);
          end
          pay = (corrupt == 0) ? c : (c ^ (8'h01 << t));
          sendByte(pay);
          c = refByte(c, pay);
          check("R8 residue crc", crcOut, c);
          check("R8 residue flag", match, (c == 8'h00));
          @(negedge clk);
          check("R8 done one cycle", done, 1'b0);
        end
      end
    end

    finishRun();
  end

endmodule